// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Controller

This block decides when the secondary-side synchronous rectifier switch of a flyback converter may conduct. It takes comparator flags that are already synchronised to the system clock and produces one drive-enable bit for the gate driver. The flags are: the switch body diode conducting, the switch current reaching zero, an external turn-off request, and two supply-monitor levels.

A reset-dominant drive latch holds the switch state. After each turn-on, a minimum on-time counter hides the zero-current flag, so drain ringing cannot end the pulse early. After every turn-off, a minimum off-time counter blocks new turn-on, so ringing below ground at light load cannot re-fire the switch. The external request and the loss of supply end conduction even while the on-time blanking is running. The external request also drops the output in the same cycle, through a combinational gate after the state register. Both blanking periods come from 16-bit cycle-count inputs. Each period is sampled when its counter starts, and a zero period gives no blanking. The pins are plain control and status levels. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `sr_gate_ctrl`

## Requirements
- R1: After reset `drv_en` is 0 and `phase` is 0 (idle).
- R2: Drive is allowed one cycle after `sup_rise_ok` is seen high. It is withdrawn one cycle after `sup_fall_ok` is seen low, and only a new `sup_rise_ok` enables it again. While drive is withdrawn, `cond_det` is ignored. If the switch was on, `drv_en` falls one cycle after supply is withdrawn.
- R3: Start from idle, with drive allowed and no trigger. If `cond_det` is 1 and `zc_det` is 0, `drv_en` rises after the next clock edge. If `cond_det` and `zc_det` are both 1, the clear wins and `drv_en` stays 0.
- R4: After turn-on, `zc_det` is ignored for P = `on_blank_cyc` cycles. With `zc_det` held high, `drv_en` is high for exactly P+1 cycles. P = 0 gives 1 cycle.
- R5: After any turn-off, `cond_det` is ignored for M = `off_blank_cyc` cycles. With `cond_det` held high from the first off cycle, `drv_en` is low for exactly M+1 cycles.
- R6: `trig_off` high forces `drv_en` to 0 in the same cycle, even during on-time blanking. While `trig_off` is high, no turn-on occurs. A turn-off by trigger or by supply loss enters off-time blanking (`phase` 3).
- R7: Each period is sampled when its counter starts. A change to the period input during blanking does not alter the current interval.
- R8: `phase` reports 0 for idle, 1 for on and blanked, 2 for on, and 3 for off and blanked. After P+2 cycles on with no clear request, `phase` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_det | input | 1 | Body-diode conduction seen (turn-on request) |
| zc_det | input | 1 | Switch current at zero (turn-off request) |
| trig_off | input | 1 | External forced turn-off, level sensitive |
| sup_rise_ok | input | 1 | Supply above the rising threshold |
| sup_fall_ok | input | 1 | Supply above the falling threshold |
| on_blank_cyc | input | 16 | Minimum on-time in clock cycles |
| off_blank_cyc | input | 16 | Minimum off-time in clock cycles |
| drv_en | output | 1 | Gate drive enable |
| phase | output | 2 | Current phase: 0 idle, 1 on-blanked, 2 on, 3 off-blanked |

## Verification
The bench measures the exact high and low widths against the P+1 and M+1 rules for several periods, including zero. An off-by-one in either counter, or a clear that leaks through blanking, shows up as a wrong width. It drives `cond_det` and `zc_det` together, so a set-dominant latch would turn on. It raises the trigger in mid-blanking and checks the output in the same cycle, which catches a masked or registered trigger and a turn-off that skips off-time blanking. It also rewrites a period during blanking to catch a counter that tracks its input live. Finally it removes supply while the switch is on, which exposes a design that keeps driving or that re-arms without the rising flag.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_ON_BLANK  = 2'd1,
    PH_ON        = 2'd2,
    PH_OFF_BLANK = 2'd3
  } sr_phase_e;
endpackage

// File: rtl/sr_supply_gate.sv
module sr_supply_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rise_ok,
  input  logic sup_fall_ok,
  output logic sup_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sup_en <= 1'b0;
    else if (!sup_en && sup_rise_ok)   sup_en <= 1'b1;
    else if (sup_en && !sup_fall_ok)   sup_en <= 1'b0;
  end

  AST_SUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && sup_fall_ok) |=> sup_en); // R2
endmodule

// File: rtl/sr_blank_timer.sv
module sr_blank_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] period,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= period;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy) |=> !busy); // R7
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_det,
  input  logic             zc_det,
  input  logic             trig_off,
  input  logic             sup_rise_ok,
  input  logic             sup_fall_ok,
  input  logic [CNT_W-1:0] on_blank_cyc,
  input  logic [CNT_W-1:0] off_blank_cyc,
  output logic             drv_en,
  output logic [1:0]       phase
);
  import sr_gate_pkg::*;

  sr_phase_e st_q, st_d;
  logic sup_en, on_busy, off_busy, on_go, off_go, kill, set_req, st_on;

  sr_supply_gate u_sup (
    .clk(clk), .rst_n(rst_n), .sup_rise_ok(sup_rise_ok),
    .sup_fall_ok(sup_fall_ok), .sup_en(sup_en)
  );

  sr_blank_timer #(.CNT_W(CNT_W)) u_on_tmr (
    .clk(clk), .rst_n(rst_n), .start(on_go), .period(on_blank_cyc), .busy(on_busy)
  );

  sr_blank_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .start(off_go), .period(off_blank_cyc), .busy(off_busy)
  );

  assign kill    = trig_off | ~sup_en;
  assign set_req = cond_det & ~zc_det & ~kill;

  always_comb begin
    st_d   = st_q;
    on_go  = 1'b0;
    off_go = 1'b0;
    unique case (st_q)
      PH_IDLE, PH_OFF_BLANK: begin
        if ((st_q == PH_IDLE || !off_busy) && set_req) begin
          on_go = 1'b1;
          st_d  = (on_blank_cyc == '0) ? PH_ON : PH_ON_BLANK;
        end else if (st_q == PH_OFF_BLANK && !off_busy) begin
          st_d = PH_IDLE;
        end
      end
      PH_ON_BLANK: begin
        if (kill || (!on_busy && zc_det)) off_go = 1'b1;
        else if (!on_busy)                st_d   = PH_ON;
      end
      PH_ON: begin
        if (kill || zc_det) off_go = 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
    if (off_go) st_d = (off_blank_cyc == '0) ? PH_IDLE : PH_OFF_BLANK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  assign st_on  = (st_q == PH_ON_BLANK) || (st_q == PH_ON);
  assign drv_en = st_on & ~trig_off;
  assign phase  = st_q;

  AST_SUPPLY_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en |=> !drv_en); // R2
  AST_RESET_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_on && cond_det && zc_det) |=> !st_on); // R3
  AST_ZC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_ON_BLANK && on_busy && !kill) |=> st_on); // R4
  AST_SET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_OFF_BLANK && off_busy) |=> !st_on); // R5
  AST_TRIG_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && trig_off) |=> !st_on); // R6
endmodule

// File: tb/test_sr_gate_ctrl.sv
module test_sr_gate_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cond_det = 0, zc_det = 0, trig_off = 0, sup_rise_ok = 0, sup_fall_ok = 0;
  logic [15:0] on_blank_cyc = 0, off_blank_cyc = 0;
  logic drv_en;
  logic [1:0] phase;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sr_gate_ctrl i_sr_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cond_det(cond_det), .zc_det(zc_det),
    .trig_off(trig_off), .sup_rise_ok(sup_rise_ok), .sup_fall_ok(sup_fall_ok),
    .on_blank_cyc(on_blank_cyc), .off_blank_cyc(off_blank_cyc),
    .drv_en(drv_en), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); cond_det = 0; zc_det = 1; trig_off = 0;
    repeat (30) @(negedge clk);
    zc_det = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 drv after reset", drv_en, 0);
    check("R1 phase after reset", phase, 0);
  endtask

  task automatic t_supply();
    int hi = 0;
    @(negedge clk); on_blank_cyc = 0; off_blank_cyc = 0; cond_det = 1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); hi += drv_en; end
    check("R2 no drive before rising flag", hi, 0);
    cond_det = 0; sup_rise_ok = 1; sup_fall_ok = 1;
    @(negedge clk); sup_rise_ok = 0; cond_det = 1;
    @(negedge clk);
    check("R3 turn-on one cycle after request", drv_en, 1);
    settle();
  endtask

  task automatic t_widths(input int p, input int m);
    int hi = 0, lo = 0;
    @(negedge clk); on_blank_cyc = 16'(p); off_blank_cyc = 16'(m); cond_det = 1; zc_det = 0;
    @(negedge clk); cond_det = 0; zc_det = 1;
    while (drv_en && hi < 1000) begin hi++; @(negedge clk); end
    check($sformatf("R4 on width P=%0d", p), hi, p + 1);
    zc_det = 0; cond_det = 1;
    while (!drv_en && lo < 1000) begin lo++; @(negedge clk); end
    check($sformatf("R5 off width M=%0d", m), lo, m + 1);
    settle();
  endtask

  task automatic t_reset_dom();
    int hi = 0;
    @(negedge clk); cond_det = 1; zc_det = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); hi += drv_en; end
    check("R3 clear wins over set", hi, 0);
    check("R3 phase stays idle", phase, 0);
    cond_det = 0; zc_det = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_phase();
    @(negedge clk); on_blank_cyc = 3; off_blank_cyc = 4; cond_det = 1;
    @(negedge clk); cond_det = 0;
    check("R8 phase on-blanked", phase, 1);
    repeat (5) @(negedge clk);
    check("R8 phase on", phase, 2);
    zc_det = 1;
    @(negedge clk);
    check("R8 phase off-blanked", phase, 3);
    zc_det = 0;
    repeat (10) @(negedge clk);
    check("R8 phase idle", phase, 0);
  endtask

  task automatic t_sample();
    int hi = 0;
    @(negedge clk); on_blank_cyc = 10; off_blank_cyc = 2; cond_det = 1;
    @(negedge clk); cond_det = 0; zc_det = 1; on_blank_cyc = 2;
    while (drv_en && hi < 1000) begin hi++; @(negedge clk); end
    check("R7 period latched at start", hi, 11);
    settle();
  endtask

  task automatic t_trig();
    int hi = 0;
    @(negedge clk); on_blank_cyc = 20; off_blank_cyc = 5; cond_det = 1;
    @(negedge clk); cond_det = 0;
    repeat (2) @(negedge clk);
    trig_off = 1;
    #1;
    check("R6 trigger drops drive in same cycle", drv_en, 0);
    @(negedge clk);
    check("R6 trigger turn-off enters off-blank", phase, 3);
    trig_off = 0;
    #1;
    check("R6 drive stays off after trigger", drv_en, 0);
    repeat (20) @(negedge clk);
    trig_off = 1; cond_det = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); hi += drv_en; end
    check("R6 no turn-on while trigger high", hi, 0);
    trig_off = 0; cond_det = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_supply_loss();
    int hi = 0;
    @(negedge clk); on_blank_cyc = 20; off_blank_cyc = 3; cond_det = 1;
    @(negedge clk); cond_det = 0; sup_fall_ok = 0;
    @(negedge clk);
    @(negedge clk);
    check("R2 drive off after supply loss", drv_en, 0);
    check("R6 supply loss enters off-blank", phase, 3);
    cond_det = 1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); hi += drv_en; end
    check("R2 turn-on ignored without supply", hi, 0);
    cond_det = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_supply();
    t_widths(5, 7);
    t_widths(0, 0);
    t_widths(12, 3);
    t_reset_dom();
    t_phase();
    t_sample();
    t_trig();
    t_supply_loss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule